// File: doc/BRIEF.md
# Spike and Zero-Run Frame Buffer

This block holds one frame of a sparse sample stream ahead of a compressive-sensing accumulator bank, keeping only what is needed to rebuild the frame. Samples inside a spike window are stored at full width. Each stretch of out-of-window samples between windows is stored only as a count of zeros. Zeros after the last window of a frame are not stored at all, because the frame length already implies them. When the whole frame has arrived, the block replays it one sample per accepted cycle. It inserts zeros for every stored gap and pads the tail, so the consumer sees exactly the original frame length with every spike sample back at its original position.

Storage holds two banks. One frame can be captured while the previous one replays, which matters because the sparsity of a frame has to be known before compression of that frame begins. With each replayed frame the block reports how many window samples the frame contained, and whether the store ran out of entries. Storage is entry based: a window opener carries the preceding gap count together with its first sample. Later window samples are plain data entries. A gap too long for the count field is cut into extra run entries, each holding the largest count.

Top module: `zrb_frame_buffer`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: Each captured frame replays exactly `frame_len` samples, and `out_last` is high on the final one only.
- R3: A sample inside a spike window replays with its input value at its original position. Every sample outside a window replays as 0, whatever value was presented for it.
- R4: A sample with `in_start` high and no window open starts a window of WIN_LEN samples (default 50), that sample included. `in_start` has no effect while a window is open. A window still open when the frame ends is cut there and does not continue into the next frame.
- R5: A gap longer than 2^RUN_W-1 zeros (default 127) is stored as extra run entries, each of the largest count, and still replays as the exact number of zeros.
- R6: Zeros after the last window of a frame use no entry unless they exceed 2^RUN_W-1. A frame that needs exactly DEPTH entries reports no overflow.
- R7: While a frame replays, `out_spikes` gives the number of window samples that frame contained.
- R8: A frame that needs more than DEPTH entries replays with `out_ovf` = 1. Entries beyond capacity are dropped, so their samples replay as 0. The frame length is unchanged.
- R9: While one frame replays, a second frame is accepted into the other bank. When both banks hold frames, `in_ready` stays 0 until a replay completes.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_last` hold their values.
- R11: `cfg_frame_len` is taken on the first accepted sample of a frame. Later changes during that frame have no effect on its length.
- R12: Windows that touch each other (a gap of zero) replay back to back with no zero between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_frame_len | input | FLEN_W | Frame length in samples (at least 1), taken on the first sample of each frame |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | A capture bank is free to take the sample |
| in_start | input | 1 | Window-start marker for this sample |
| in_data | input | DATA_W | Input sample value |
| out_valid | output | 1 | Replayed sample valid |
| out_ready | input | 1 | Consumer takes the replayed sample |
| out_data | output | DATA_W | Replayed sample value |
| out_last | output | 1 | Final sample of the replayed frame |
| out_spikes | output | FLEN_W | Window-sample count of the replayed frame |
| out_ovf | output | 1 | Entry capacity was exceeded in the replayed frame |

## Verification
The bench targets the boundaries of the entry format. These are windows that touch, a start marker inside an open window, a window cut at the frame end, a gap long enough to split twice, a frame that fills the store exactly, and one that overflows it. A design that stored trailing zeros or split runs one count early would flag overflow on the exactly-full frame. A design that mishandled a zero gap or a restart would shift every later sample by one or more positions. A design that replayed dropped entries, or stopped at the last stored entry, would emit a frame of the wrong length or put stale values where zeros belong. Two frames are queued with the consumer idle to show that capture stalls, rather than overwriting, when both banks are full.

// File: rtl/zrb_pkg.sv
package zrb_pkg;
  typedef enum logic [1:0] {
    ENT_DATA = 2'd0,
    ENT_HEAD = 2'd1,
    ENT_RUN  = 2'd2
  } ent_kind_e;
endpackage

// File: rtl/zrb_writer.sv
module zrb_writer
  import zrb_pkg::*;
#(
  parameter int DATA_W  = 10,
  parameter int FLEN_W  = 10,
  parameter int WIN_LEN = 50,
  parameter int RUN_W   = 7,
  parameter int DEPTH   = 128,
  localparam int PW     = $clog2(DEPTH + 1),
  localparam int AW     = $clog2(DEPTH),
  localparam int WW     = $clog2(WIN_LEN + 1),
  localparam int ENT_W  = 2 + RUN_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLEN_W-1:0] cfg_frame_len,
  input  logic              in_valid,
  input  logic              in_start,
  input  logic [DATA_W-1:0] in_data,
  input  logic [1:0]        bank_full,
  output logic              in_ready,
  output logic              wr_en,
  output logic              wr_bank,
  output logic [AW-1:0]     wr_addr,
  output logic [ENT_W-1:0]  wr_entry,
  output logic              drop_evt,
  output logic              commit,
  output logic [PW-1:0]     commit_entries,
  output logic [FLEN_W-1:0] commit_flen,
  output logic [FLEN_W-1:0] commit_spikes,
  output logic              commit_ovf
);
  localparam logic [RUN_W-1:0] RUN_MAX = {RUN_W{1'b1}};
  localparam logic [PW-1:0]    CAP     = PW'(DEPTH);
  localparam logic [WW-1:0]    WIN_M1  = WW'(WIN_LEN - 1);

  function automatic logic [ENT_W-1:0] pack_entry(ent_kind_e k, logic [RUN_W-1:0] g,
                                                  logic [DATA_W-1:0] d);
    return {k, g, d};
  endfunction

  logic              wb;
  logic [FLEN_W-1:0] smp_cnt, flen_q, spk_cnt;
  logic [RUN_W-1:0]  gap_cnt;
  logic [WW-1:0]     win_left;
  logic [PW-1:0]     wr_ptr;
  logic              ovf_q;

  logic              acc, open_win, in_win, spike, run_flush, need_wr, room, last;
  logic [FLEN_W-1:0] cur_len;
  ent_kind_e         kind;
  logic [RUN_W-1:0]  gap_f;

  always_comb begin
    in_ready  = !bank_full[wb];
    acc       = in_valid && in_ready;
    cur_len   = (smp_cnt == '0) ? cfg_frame_len : flen_q;
    in_win    = (win_left != '0);
    open_win  = in_start && !in_win;
    spike     = open_win || in_win;
    run_flush = !spike && (gap_cnt == RUN_MAX);
    need_wr   = acc && (spike || run_flush);
    room      = (wr_ptr < CAP);
    wr_en     = need_wr && room;
    drop_evt  = need_wr && !room;
    last      = acc && (smp_cnt == cur_len - 1'b1);
    kind      = open_win ? ENT_HEAD : (in_win ? ENT_DATA : ENT_RUN);
    gap_f     = open_win ? gap_cnt : (run_flush ? RUN_MAX : '0);
    wr_entry  = pack_entry(kind, gap_f, spike ? in_data : '0);
    wr_bank   = wb;
    wr_addr   = wr_ptr[AW-1:0];
    commit         = last;
    commit_entries = wr_ptr + PW'(wr_en);
    commit_flen    = cur_len;
    commit_spikes  = spk_cnt + FLEN_W'(spike);
    commit_ovf     = ovf_q || drop_evt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb <= 1'b0; smp_cnt <= '0; flen_q <= '0; spk_cnt <= '0;
      gap_cnt <= '0; win_left <= '0; wr_ptr <= '0; ovf_q <= 1'b0;
    end else if (acc) begin
      if (last) begin
        wb <= !wb; smp_cnt <= '0; spk_cnt <= '0; gap_cnt <= '0;
        win_left <= '0; wr_ptr <= '0; ovf_q <= 1'b0;
      end else begin
        smp_cnt <= smp_cnt + 1'b1;
        flen_q  <= cur_len;
        spk_cnt <= commit_spikes;
        wr_ptr  <= commit_entries;
        ovf_q   <= commit_ovf;
        if (open_win) begin
          gap_cnt  <= '0;
          win_left <= WIN_M1;
        end else if (in_win) begin
          win_left <= win_left - 1'b1;
        end else begin
          gap_cnt <= run_flush ? RUN_W'(1) : gap_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/zrb_store.sv
module zrb_store #(
  parameter int DATA_W = 10,
  parameter int FLEN_W = 10,
  parameter int RUN_W  = 7,
  parameter int DEPTH  = 128,
  localparam int PW    = $clog2(DEPTH + 1),
  localparam int AW    = $clog2(DEPTH),
  localparam int ENT_W = 2 + RUN_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_bank,
  input  logic [AW-1:0]     wr_addr,
  input  logic [ENT_W-1:0]  wr_entry,
  input  logic              commit,
  input  logic [PW-1:0]     commit_entries,
  input  logic [FLEN_W-1:0] commit_flen,
  input  logic [FLEN_W-1:0] commit_spikes,
  input  logic              commit_ovf,
  input  logic              rd_bank,
  input  logic [AW-1:0]     rd_addr,
  input  logic              release_bank,
  output logic [ENT_W-1:0]  rd_entry,
  output logic [1:0]        bank_full,
  output logic [PW-1:0]     m_entries,
  output logic [FLEN_W-1:0] m_flen,
  output logic [FLEN_W-1:0] m_spikes,
  output logic              m_ovf
);
  logic [ENT_W-1:0]  mem [2*DEPTH];
  logic [PW-1:0]     ent_q  [2];
  logic [FLEN_W-1:0] flen_q [2];
  logic [FLEN_W-1:0] spk_q  [2];
  logic [1:0]        ovf_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[{wr_bank, wr_addr}] <= wr_entry;
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bank_full[b] <= 1'b0;
        ent_q[b]     <= '0;
        flen_q[b]    <= '0;
        spk_q[b]     <= '0;
        ovf_q[b]     <= 1'b0;
      end else if (commit && (wr_bank == 1'(b))) begin
        bank_full[b] <= 1'b1;
        ent_q[b]     <= commit_entries;
        flen_q[b]    <= commit_flen;
        spk_q[b]     <= commit_spikes;
        ovf_q[b]     <= commit_ovf;
      end else if (release_bank && (rd_bank == 1'(b))) begin
        bank_full[b] <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_entry  = mem[{rd_bank, rd_addr}];
    m_entries = ent_q[rd_bank];
    m_flen    = flen_q[rd_bank];
    m_spikes  = spk_q[rd_bank];
    m_ovf     = ovf_q[rd_bank];
  end
endmodule

// File: rtl/zrb_replay.sv
module zrb_replay
  import zrb_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int FLEN_W = 10,
  parameter int RUN_W  = 7,
  parameter int DEPTH  = 128,
  localparam int PW    = $clog2(DEPTH + 1),
  localparam int AW    = $clog2(DEPTH),
  localparam int ENT_W = 2 + RUN_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bank_full,
  input  logic [ENT_W-1:0]  rd_entry,
  input  logic [PW-1:0]     m_entries,
  input  logic [FLEN_W-1:0] m_flen,
  input  logic              out_ready,
  output logic              rd_bank,
  output logic [AW-1:0]     rd_addr,
  output logic              release_bank,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic              fire,
  output logic              tail_zone
);
  function automatic ent_kind_e ent_kind(logic [ENT_W-1:0] e);
    return ent_kind_e'(e[ENT_W-1 -: 2]);
  endfunction
  function automatic logic [RUN_W-1:0] ent_gap(logic [ENT_W-1:0] e);
    return e[DATA_W +: RUN_W];
  endfunction

  logic              rb, gap_done, gd_nx;
  logic [FLEN_W-1:0] emit_cnt;
  logic [PW-1:0]     rd_ptr, ptr_nx;
  logic [RUN_W-1:0]  zleft, zl_nx, gap;
  logic              have_ent;

  always_comb begin
    gap       = ent_gap(rd_entry);
    have_ent  = (rd_ptr < m_entries);
    out_valid = bank_full[rb];
    out_last  = out_valid && (emit_cnt == m_flen - 1'b1);
    fire      = out_valid && out_ready;
    release_bank = fire && out_last;
    rd_bank   = rb;
    rd_addr   = rd_ptr[AW-1:0];
    zl_nx     = zleft;
    ptr_nx    = rd_ptr;
    gd_nx     = gap_done;
    out_data  = '0;
    tail_zone = 1'b0;
    if (zleft != '0) begin
      zl_nx = zleft - 1'b1;
    end else if (!have_ent) begin
      tail_zone = 1'b1;
    end else begin
      unique case (ent_kind(rd_entry))
        ENT_RUN: begin
          zl_nx  = gap - 1'b1;
          ptr_nx = rd_ptr + 1'b1;
        end
        ENT_HEAD: begin
          if (!gap_done && gap != '0) begin
            zl_nx = gap - 1'b1;
            gd_nx = 1'b1;
          end else begin
            out_data = rd_entry[DATA_W-1:0];
            ptr_nx   = rd_ptr + 1'b1;
            gd_nx    = 1'b0;
          end
        end
        default: begin
          out_data = rd_entry[DATA_W-1:0];
          ptr_nx   = rd_ptr + 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rb <= 1'b0; emit_cnt <= '0; rd_ptr <= '0; zleft <= '0; gap_done <= 1'b0;
    end else if (fire) begin
      if (out_last) begin
        rb <= !rb; emit_cnt <= '0; rd_ptr <= '0; zleft <= '0; gap_done <= 1'b0;
      end else begin
        emit_cnt <= emit_cnt + 1'b1;
        rd_ptr   <= ptr_nx;
        zleft    <= zl_nx;
        gap_done <= gd_nx;
      end
    end
  end
endmodule

// File: rtl/zrb_frame_buffer.sv
module zrb_frame_buffer
  import zrb_pkg::*;
#(
  parameter int DATA_W  = 10,
  parameter int FLEN_W  = 10,
  parameter int WIN_LEN = 50,
  parameter int RUN_W   = 7,
  parameter int DEPTH   = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLEN_W-1:0] cfg_frame_len,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_start,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic [FLEN_W-1:0] out_spikes,
  output logic              out_ovf
);
  localparam int PW    = $clog2(DEPTH + 1);
  localparam int AW    = $clog2(DEPTH);
  localparam int ENT_W = 2 + RUN_W + DATA_W;

  logic              wr_en, wr_bank, drop_evt, commit, commit_ovf;
  logic [AW-1:0]     wr_addr, rd_addr;
  logic [ENT_W-1:0]  wr_entry, rd_entry;
  logic [PW-1:0]     commit_entries, m_entries;
  logic [FLEN_W-1:0] commit_flen, commit_spikes, m_flen;
  logic              rd_bank, release_bank, fire, tail_zone;
  logic [1:0]        bank_full;
  logic              run_wr;
  logic [RUN_W-1:0]  run_gap;

  assign run_wr  = wr_en && (ent_kind_e'(wr_entry[ENT_W-1 -: 2]) == ENT_RUN);
  assign run_gap = wr_entry[DATA_W +: RUN_W];

  zrb_writer #(.DATA_W(DATA_W), .FLEN_W(FLEN_W), .WIN_LEN(WIN_LEN), .RUN_W(RUN_W),
               .DEPTH(DEPTH)) u_wr (
    .clk(clk), .rst_n(rst_n), .cfg_frame_len(cfg_frame_len), .in_valid(in_valid),
    .in_start(in_start), .in_data(in_data), .bank_full(bank_full), .in_ready(in_ready),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr), .wr_entry(wr_entry),
    .drop_evt(drop_evt), .commit(commit), .commit_entries(commit_entries),
    .commit_flen(commit_flen), .commit_spikes(commit_spikes), .commit_ovf(commit_ovf)
  );

  zrb_store #(.DATA_W(DATA_W), .FLEN_W(FLEN_W), .RUN_W(RUN_W), .DEPTH(DEPTH)) u_st (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr),
    .wr_entry(wr_entry), .commit(commit), .commit_entries(commit_entries),
    .commit_flen(commit_flen), .commit_spikes(commit_spikes), .commit_ovf(commit_ovf),
    .rd_bank(rd_bank), .rd_addr(rd_addr), .release_bank(release_bank),
    .rd_entry(rd_entry), .bank_full(bank_full), .m_entries(m_entries),
    .m_flen(m_flen), .m_spikes(out_spikes), .m_ovf(out_ovf)
  );

  zrb_replay #(.DATA_W(DATA_W), .FLEN_W(FLEN_W), .RUN_W(RUN_W), .DEPTH(DEPTH)) u_rp (
    .clk(clk), .rst_n(rst_n), .bank_full(bank_full), .rd_entry(rd_entry),
    .m_entries(m_entries), .m_flen(m_flen), .out_ready(out_ready), .rd_bank(rd_bank),
    .rd_addr(rd_addr), .release_bank(release_bank), .out_valid(out_valid),
    .out_data(out_data), .out_last(out_last), .fire(fire), .tail_zone(tail_zone)
  );
endmodule

// File: rtl/zrb_frame_buffer_chk.sv
module zrb_frame_buffer_chk #(
  parameter int DATA_W = 10,
  parameter int FLEN_W = 10,
  parameter int RUN_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_last,
  input logic [FLEN_W-1:0] out_spikes,
  input logic [FLEN_W-1:0] m_flen,
  input logic              fire,
  input logic              tail_zone,
  input logic              wr_en,
  input logic              wr_bank,
  input logic [1:0]        bank_full,
  input logic              run_wr,
  input logic [RUN_W-1:0]  run_gap
);
  logic [FLEN_W-1:0] fcnt;
  always_ff @(posedge clk) begin
    if (!rst_n) fcnt <= '0;
    else if (fire) fcnt <= out_last ? '0 : fcnt + 1'b1;
  end

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));
  a_r2_frame_len: assert property (@(posedge clk) disable iff (!rst_n)
    fire && out_last |-> fcnt == m_flen - 1'b1);
  a_r3_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && tail_zone |-> out_data == '0);
  a_r9_free_bank: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !bank_full[wr_bank]);
  a_r5_run_max: assert property (@(posedge clk) disable iff (!rst_n)
    run_wr |-> &run_gap);
  a_r7_spike_bound: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_spikes <= m_flen);
endmodule

bind zrb_frame_buffer zrb_frame_buffer_chk #(.DATA_W(DATA_W), .FLEN_W(FLEN_W), .RUN_W(RUN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_last(out_last), .out_spikes(out_spikes), .m_flen(m_flen),
  .fire(fire), .tail_zone(tail_zone), .wr_en(wr_en), .wr_bank(wr_bank),
  .bank_full(bank_full), .run_wr(run_wr), .run_gap(run_gap)
);

// File: tb/zrb_frame_buffer_test.sv
module zrb_frame_buffer_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 10, FW = 8, WIN = 4, RW = 4, DEP = 16;
  localparam int RMAX = 15;

  logic clk = 0, rst_n = 0;
  logic [FW-1:0] cfg_frame_len = '0;
  logic in_valid = 0, in_start = 0, out_ready = 0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, out_valid, out_last, out_ovf;
  logic [DW-1:0] out_data;
  logic [FW-1:0] out_spikes;

  int total = 0, bad = 0;
  logic [DW-1:0] sd [4][256];
  bit ss [4][256];
  int fl [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  zrb_frame_buffer #(.DATA_W(DW), .FLEN_W(FW), .WIN_LEN(WIN), .RUN_W(RW), .DEPTH(DEP)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_frame_len(cfg_frame_len), .in_valid(in_valid),
    .in_ready(in_ready), .in_start(in_start), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .out_spikes(out_spikes), .out_ovf(out_ovf)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_frame(int s, int len);
    fl[s] = len;
    for (int j = 0; j < 256; j++) begin
      sd[s][j] = DW'($urandom_range(1, 1023));
      ss[s][j] = 0;
    end
  endtask

  task automatic send_frame(int s);
    int i = 0;
    while (i < fl[s]) begin
      @(negedge clk);
      in_valid = 1; in_data = sd[s][i]; in_start = ss[s][i];
      cfg_frame_len = (i == 0) ? FW'(fl[s]) : FW'(fl[s] + 3); // R11: later changes ignored
      if (in_ready) i++;
    end
    @(negedge clk);
    in_valid = 0; in_start = 0;
  endtask

  task automatic recv_frame(int s, bit stall, string tag);
    logic [DW-1:0] exp [256];
    int win = 0, gap = 0, ent = 0, spk = 0, cnt = 0, dbad = 0, hbad = 0, cyc = 0;
    int got_spk = -1, got_ovf = -1;
    bit done = 0, hold_p = 0;
    logic [DW-1:0] hold_d = '0;
    for (int j = 0; j < fl[s]; j++) begin
      if (ss[s][j] && win == 0) begin
        exp[j] = (ent < DEP) ? sd[s][j] : '0; ent++; spk++; win = WIN - 1; gap = 0;
      end else if (win > 0) begin
        exp[j] = (ent < DEP) ? sd[s][j] : '0; ent++; spk++; win--;
      end else begin
        exp[j] = '0;
        if (gap == RMAX) begin ent++; gap = 1; end else gap++;
      end
    end
    while (!done) begin
      @(negedge clk);
      out_ready = stall ? (cyc % 3 != 2) : 1'b1;
      cyc++;
      if (hold_p) begin
        if (!(out_valid && out_data == hold_d)) hbad++;
        hold_p = 0;
      end
      if (out_valid) begin
        if (out_ready) begin
          if (cnt == 0) begin got_spk = int'(out_spikes); got_ovf = int'(out_ovf); end
          if (cnt < fl[s] && out_data !== exp[cnt]) dbad++;
          cnt++;
          if (out_last || cnt > fl[s]) done = 1;
        end else begin
          hold_p = 1; hold_d = out_data;
        end
      end
    end
    @(negedge clk);
    out_ready = 0;
    chk(cnt == fl[s], {"R2 length ", tag}, cnt, fl[s]);
    chk(dbad == 0, {"R3 data ", tag}, dbad, 0);
    chk(got_spk == spk, {"R7 spikes ", tag}, got_spk, spk);
    chk(got_ovf == int'(ent > DEP), {"R8 R6 overflow ", tag}, got_ovf, int'(ent > DEP));
    if (stall) chk(hbad == 0, {"R10 hold ", tag}, hbad, 0);
  endtask

  task automatic run_frame(int s, bit stall, string tag);
    fork
      send_frame(s);
      recv_frame(s, stall, tag);
    join
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0, "R1 out_valid", int'(out_valid), 0);
    chk(in_ready == 1, "R1 in_ready", int'(in_ready), 1);
  endtask

  task automatic t_basic; // R3 R7 R11
    set_frame(0, 40); ss[0][5] = 1; ss[0][20] = 1;
    run_frame(0, 0, "basic");
  endtask

  task automatic t_adjacent; // R4 R12: touching windows, restart ignored, cut at end
    set_frame(1, 40); ss[1][3] = 1; ss[1][7] = 1; ss[1][8] = 1; ss[1][38] = 1;
    sd[1][7] = '0;
    run_frame(1, 0, "adjacent");
  endtask

  task automatic t_longgap; // R5 split runs, R10 stall
    set_frame(2, 100); ss[2][60] = 1; ss[2][96] = 1;
    run_frame(2, 1, "longgap");
  endtask

  task automatic t_exact; // R6: exactly DEP entries, 15 trailing zeros
    set_frame(3, 49); ss[3][0] = 1; ss[3][10] = 1; ss[3][20] = 1; ss[3][30] = 1;
    run_frame(3, 0, "exact");
  endtask

  task automatic t_overflow; // R8
    set_frame(0, 60);
    for (int k = 0; k < 5; k++) ss[0][k*10] = 1;
    run_frame(0, 1, "overflow");
  endtask

  task automatic t_dual; // R9 double bank
    set_frame(1, 30); ss[1][2] = 1;
    set_frame(2, 20); ss[2][0] = 1;
    set_frame(3, 25); ss[3][24] = 1;
    out_ready = 0;
    send_frame(1);
    send_frame(2);
    @(negedge clk);
    chk(in_ready == 0, "R9 both banks full", int'(in_ready), 0);
    chk(out_valid == 1, "R9 first frame pending", int'(out_valid), 1);
    fork
      begin recv_frame(1, 0, "dualA"); recv_frame(2, 1, "dualB"); recv_frame(3, 0, "dualC"); end
      send_frame(3);
    join
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_adjacent();
    t_longgap();
    t_exact();
    t_overflow();
    t_dual();
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule